// File: doc/BRIEF.md
# OTP Fuse Command Controller

This block sits between a 32-bit register bus and a one-time-programmable fuse array organised as 128-bit words. Software writes a byte address and, for a program, four data words and four admin words. It then writes a start bit with an operation code into the command register. The controller checks the address and the write-protect state. After a fixed number of cycles it either copies the addressed word into the read payload and admin registers, or ORs the program payload into the array.

Each stored word carries a valid flag in bit 0 of its first admin word, and every successful program sets that flag. Software can therefore tell a location that has never been written from a failed read. A never-written location reads back as all zeros with a clear read status. A failed read returns all zeros with the permission-error flag set.

Programming is allowed only when two protections are both released. One is a software protect bit in the protect register, which resets to the locked value. The other is an external protect pin, sampled when the command completes.

The bus is a single-cycle register interface. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is a combinational function of `bus_addr`.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, status bit 0 (ready) is 1, command bit 16 (done) is 0, protect register bit 3 (software protect) is 1, and read status bits 0 and 3 are 0.
- R2: The command register at 0x14 has start at bit 0, the operation at bits 7:4 (0xF read, 0xA program) and done at bit 16. A start write is accepted only while ready is 1. A start written while busy is ignored, and the stored operation then keeps its previous value.
- R3: Ready reads 0 in the cycle after a start is accepted. Done clears at that same acceptance. Done and ready both read 1 from LATENCY cycles after the accepting clock edge.
- R4: A read of a valid address loads its data words into 0x20, 0x24, 0x28, 0x2C and its admin words into 0x30 to 0x3C, lowest word first. It clears read status bit 0 (permission error) and bit 3 (data error).
- R5: A program finishes with permission error set and the array unchanged if either protect is active when it completes. The protects are protect register bit 3 (software) and the `ext_wp_i` pin, which reads back at protect bit 30.
- R6: A program with both protects released ORs the four data words at 0x40 to 0x4C and the four admin words at 0x50 to 0x5C into the word at the address register (0x10). It forces admin word 0 bit 0 (valid) to 1 and clears the permission error.
- R7: An address that has nonzero bits 3:0, is below WIN_BASE, or is at or above WIN_BASE+WIN_BYTES (0x1000 and 0x2000 by default) sets the permission error. A read of such an address returns zero in all eight read payload words. A program to such an address writes nothing.
- R8: A location that has never been programmed reads back as zero data, zero admin words and read status 0.
- R9: Fuse bits only ever change from 0 to 1. A second program of a word ORs into its previous content.
- R10: Writes to the address register or to the program payload registers while ready is 0 are ignored.
- R11: An operation code other than 0xF or 0xA completes with done set and permission error set, and does not touch the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_wp_i | input | 1 | External write protect, active high |

## Verification
A register write takes effect at the rising edge where it is presented, and a register read is valid within the same cycle. The bench drives each access at a falling edge and compares the read value 1 ns later. A command's results and its done flag are due LATENCY edges after the edge that accepts the start, and ready is low from the first cycle after that edge. The timed test probes the bus once per cycle from the acceptance onward. It expects ready low on the first probe, done low on probes 2 to LATENCY, and done high on probe LATENCY+1. Every other check waits LATENCY+1 cycles after a start before reading the results.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam logic [11:0] OFS_STATUS = 12'h000;
    localparam logic [11:0] OFS_RDSTAT = 12'h004;
    localparam logic [11:0] OFS_ADDR   = 12'h010;
    localparam logic [11:0] OFS_CMD    = 12'h014;
    localparam logic [11:0] OFS_RDATA  = 12'h020;
    localparam logic [11:0] OFS_RADMIN = 12'h030;
    localparam logic [11:0] OFS_PDATA  = 12'h040;
    localparam logic [11:0] OFS_PADMIN = 12'h050;
    localparam logic [11:0] OFS_PROT   = 12'h080;

    localparam logic [3:0] OP_READ = 4'hF;
    localparam logic [3:0] OP_PROG = 4'hA;

    localparam int BIT_SWP = 3;

    typedef logic [3:0][31:0] quad_t;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output otp_pkg::quad_t     rd_data,
    output otp_pkg::quad_t     rd_admin,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  otp_pkg::quad_t     wr_data,
    input  otp_pkg::quad_t     wr_admin
);
    // Behavioural model: cleared at reset to stand for a blank array.
    logic [255:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (wr_en) begin
            cell_q[wr_idx] <= cell_q[wr_idx] | {wr_admin, wr_data};
        end
    end

    assign rd_data  = cell_q[rd_idx][127:0];
    assign rd_admin = cell_q[rd_idx][255:128];

    // Snapshot of the word before a write, for the monotonic check.
    logic [IDX_W-1:0] chk_idx_q;
    logic [255:0]     chk_old_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_idx_q <= '0;
            chk_old_q <= '0;
        end else begin
            chk_idx_q <= wr_idx;
            chk_old_q <= cell_q[wr_idx];
        end
    end

    AST_FUSE_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cell_q[chk_idx_q] & chk_old_q) == chk_old_q)); // R9
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq #(
    parameter int LATENCY = 4,
    localparam int CW = $clog2(LATENCY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o,
    output logic done_o,
    output logic fire_o
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        fire_o = seq_q.busy && (seq_q.cnt == '0);
        if (start_i && !seq_q.busy) begin
            seq_d.busy = 1'b1;
            seq_d.done = 1'b0;
            seq_d.cnt  = CW'(LATENCY - 1);
        end else if (fire_o) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ready_o = !seq_q.busy;
    assign done_o  = seq_q.done;

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ready_o) |=> (!ready_o && !done_o)); // R3
    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (ready_o && $past(!ready_o))); // R3
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl #(
    parameter logic [31:0] WIN_BASE  = 32'h0000_1000,
    parameter logic [31:0] WIN_BYTES = 32'h0000_1000,
    parameter int          LATENCY   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ext_wp_i
);
    import otp_pkg::*;

    localparam int DEPTH = int'(WIN_BYTES / 16);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  op;
        quad_t       pdata;
        quad_t       padmin;
        quad_t       rdata;
        quad_t       radmin;
        logic        perm;
        logic        swp;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             ready, done, fire, start_req, wr_hit;
    logic             addr_ok, unlocked, arr_we;
    logic [IDX_W-1:0] idx;
    quad_t            arr_data, arr_admin, prog_admin;

    assign wr_hit    = bus_sel && bus_wr;
    assign start_req = wr_hit && (bus_addr == OFS_CMD) && bus_wdata[0];
    assign addr_ok   = (regs_q.addr[3:0] == 4'h0) && (regs_q.addr >= WIN_BASE)
                       && (regs_q.addr < WIN_BASE + WIN_BYTES);
    assign idx       = IDX_W'((regs_q.addr - WIN_BASE) >> 4);
    assign unlocked  = !regs_q.swp && !ext_wp_i;

    always_comb begin
        prog_admin       = regs_q.padmin;
        prog_admin[0][0] = 1'b1;
    end

    otp_cmd_seq #(.LATENCY(LATENCY)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_req),
        .ready_o (ready),
        .done_o  (done),
        .fire_o  (fire)
    );

    otp_fuse_array #(.DEPTH(DEPTH)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_data  (arr_data),
        .rd_admin (arr_admin),
        .wr_en    (arr_we),
        .wr_idx   (idx),
        .wr_data  (regs_q.pdata),
        .wr_admin (prog_admin)
    );

    always_comb begin
        regs_d = regs_q;
        arr_we = 1'b0;
        if (wr_hit) begin
            if (bus_addr == OFS_PROT) regs_d.swp = bus_wdata[BIT_SWP];
            if (ready) begin
                if (bus_addr == OFS_ADDR) regs_d.addr = bus_wdata;
                for (int k = 0; k < 4; k++) begin
                    if (bus_addr == OFS_PDATA + 12'(4 * k))  regs_d.pdata[k]  = bus_wdata;
                    if (bus_addr == OFS_PADMIN + 12'(4 * k)) regs_d.padmin[k] = bus_wdata;
                end
                if (start_req) regs_d.op = bus_wdata[7:4];
            end
        end
        if (fire) begin
            case (regs_q.op)
                OP_READ: begin
                    regs_d.perm   = !addr_ok;
                    regs_d.rdata  = addr_ok ? arr_data  : '0;
                    regs_d.radmin = addr_ok ? arr_admin : '0;
                end
                OP_PROG: begin
                    regs_d.perm = !(addr_ok && unlocked);
                    arr_we      = addr_ok && unlocked;
                end
                default: regs_d.perm = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.swp <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STATUS: bus_rdata = {31'b0, ready};
            OFS_RDSTAT: bus_rdata = {28'b0, 1'b0, 2'b0, regs_q.perm};
            OFS_ADDR:   bus_rdata = regs_q.addr;
            OFS_CMD:    bus_rdata = {15'b0, done, 8'b0, regs_q.op, 4'b0};
            OFS_PROT:   bus_rdata = {1'b0, ext_wp_i, 26'b0, regs_q.swp, 3'b0};
            default:    bus_rdata = '0;
        endcase
        for (int k = 0; k < 4; k++) begin
            if (bus_addr == OFS_RDATA + 12'(4 * k))  bus_rdata = regs_q.rdata[k];
            if (bus_addr == OFS_RADMIN + 12'(4 * k)) bus_rdata = regs_q.radmin[k];
        end
    end

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && regs_q.op == OP_READ && regs_q.perm)
        |-> (regs_q.rdata == '0 && regs_q.radmin == '0)); // R7
    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.swp || ext_wp_i) |-> !arr_we); // R5
    AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(regs_q.addr)); // R10
endmodule

// File: tb/tb_otp_cmd_ctrl.sv
module tb_otp_cmd_ctrl;
    import otp_pkg::*;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_wp = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_q[$];
    logic [31:0] msk_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    otp_cmd_ctrl #(.LATENCY(LAT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_wp_i  (ext_wp)
    );

    // Monitor: pops one expectation per cycle in which the driver queued one.
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [31:0] e, m;
            string t;
            e = exp_q.pop_front();
            m = msk_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ((bus_rdata & m) !== (e & m)) begin
                n_bad++;
                $display("FAIL %s: reg %h actual %h expected %h", t, bus_addr, bus_rdata & m, e & m);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Driver: presents a read and pushes the expected value for the monitor.
    task automatic expect_reg(input logic [11:0] a, input logic [31:0] e,
                              input logic [31:0] m, input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    endtask

    task automatic do_cmd(input logic [3:0] op);
        wr(OFS_CMD, {24'b0, op, 4'b0001});
        repeat (LAT + 1) @(negedge clk);
    endtask

    task automatic set_payload(input logic [31:0] d0, input logic [31:0] d1,
                               input logic [31:0] a0, input logic [31:0] a1);
        wr(OFS_PDATA, d0);
        wr(OFS_PDATA + 12'h4, d1);
        wr(OFS_PADMIN, a0);
        wr(OFS_PADMIN + 12'h4, a1);
    endtask

    // R3: probe every cycle after the accepting edge.
    task automatic timed_read();
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = OFS_CMD; bus_wdata = {24'b0, OP_READ, 4'b0001};
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = OFS_STATUS;
        exp_q.push_back(32'h0); msk_q.push_back(32'h1); tag_q.push_back("R3 ready low after start");
        for (int j = 2; j <= LAT + 1; j++) begin
            @(negedge clk);
            bus_addr = OFS_CMD;
            exp_q.push_back((j <= LAT) ? 32'h0 : 32'h0001_0000);
            msk_q.push_back(32'h0001_0000);
            tag_q.push_back("R3 done timing");
        end
        expect_reg(OFS_STATUS, 32'h1, 32'h1, "R3 ready with done");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(OFS_STATUS, 32'h1, 32'h1, "R1 ready");
        expect_reg(OFS_CMD, 32'h0, 32'h0001_0000, "R1 done");
        expect_reg(OFS_PROT, 32'h8, 32'h8, "R1 soft protect");
        expect_reg(OFS_RDSTAT, 32'h0, 32'h9, "R1 read status");

        // R8 / R4 blank location
        wr(OFS_ADDR, 32'h1000);
        do_cmd(OP_READ);
        expect_reg(OFS_RDSTAT, 32'h0, 32'h9, "R8 status");
        expect_reg(OFS_RADMIN, 32'h0, 32'hFFFF_FFFF, "R8 admin0");
        expect_reg(OFS_RDATA, 32'h0, 32'hFFFF_FFFF, "R8 data0");

        // R5 soft protect blocks
        set_payload(32'h0000_00F0, 32'hCAFE_0000, 32'h0, 32'h0);
        wr(OFS_ADDR, 32'h1010);
        do_cmd(OP_PROG);
        expect_reg(OFS_RDSTAT, 32'h1, 32'h9, "R5 soft wp perm");
        do_cmd(OP_READ);
        expect_reg(OFS_RADMIN, 32'h0, 32'hFFFF_FFFF, "R5 soft wp admin");
        expect_reg(OFS_RDATA, 32'h0, 32'hFFFF_FFFF, "R5 soft wp data");

        // R5 external protect blocks
        wr(OFS_PROT, 32'h0);
        ext_wp = 1'b1;
        expect_reg(OFS_PROT, 32'h4000_0000, 32'h4000_0008, "R5 protect readback");
        do_cmd(OP_PROG);
        expect_reg(OFS_RDSTAT, 32'h1, 32'h9, "R5 ext wp perm");
        do_cmd(OP_READ);
        expect_reg(OFS_RDATA, 32'h0, 32'hFFFF_FFFF, "R5 ext wp data");

        // R6 program with protects released
        ext_wp = 1'b0;
        do_cmd(OP_PROG);
        expect_reg(OFS_RDSTAT, 32'h0, 32'h9, "R6 prog status");
        do_cmd(OP_READ);
        expect_reg(OFS_RDATA, 32'h0000_00F0, 32'hFFFF_FFFF, "R6 data0");
        expect_reg(OFS_RDATA + 12'h4, 32'hCAFE_0000, 32'hFFFF_FFFF, "R4 data1");
        expect_reg(OFS_RADMIN, 32'h1, 32'hFFFF_FFFF, "R6 valid flag");
        expect_reg(OFS_RADMIN + 12'h4, 32'h0, 32'hFFFF_FFFF, "R4 admin1");

        // R9 second program ORs
        set_payload(32'h0000_000F, 32'h0000_BEEF, 32'h0, 32'h0000_0100);
        do_cmd(OP_PROG);
        do_cmd(OP_READ);
        expect_reg(OFS_RDATA, 32'h0000_00FF, 32'hFFFF_FFFF, "R9 data0");
        expect_reg(OFS_RDATA + 12'h4, 32'hCAFE_BEEF, 32'hFFFF_FFFF, "R9 data1");
        expect_reg(OFS_RADMIN + 12'h4, 32'h0000_0100, 32'hFFFF_FFFF, "R9 admin1");
        expect_reg(OFS_RADMIN, 32'h1, 32'hFFFF_FFFF, "R9 admin0");

        // R7 bad addresses
        wr(OFS_ADDR, 32'h1014);
        do_cmd(OP_READ);
        expect_reg(OFS_RDSTAT, 32'h1, 32'h9, "R7 misaligned perm");
        expect_reg(OFS_RDATA, 32'h0, 32'hFFFF_FFFF, "R7 misaligned data0");
        expect_reg(OFS_RDATA + 12'h4, 32'h0, 32'hFFFF_FFFF, "R7 misaligned data1");
        expect_reg(OFS_RADMIN, 32'h0, 32'hFFFF_FFFF, "R7 misaligned admin0");
        wr(OFS_ADDR, 32'h2000);
        do_cmd(OP_READ);
        expect_reg(OFS_RDSTAT, 32'h1, 32'h9, "R7 above window");
        wr(OFS_ADDR, 32'h0FF0);
        do_cmd(OP_READ);
        expect_reg(OFS_RDSTAT, 32'h1, 32'h9, "R7 below window");
        wr(OFS_ADDR, 32'h1FF0);
        do_cmd(OP_READ);
        expect_reg(OFS_RDSTAT, 32'h0, 32'h9, "R7 last word valid");
        set_payload(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0);
        wr(OFS_ADDR, 32'h1018);
        do_cmd(OP_PROG);
        expect_reg(OFS_RDSTAT, 32'h1, 32'h9, "R7 misaligned prog perm");
        wr(OFS_ADDR, 32'h1010);
        do_cmd(OP_READ);
        expect_reg(OFS_RDATA, 32'h0000_00FF, 32'hFFFF_FFFF, "R7 misaligned prog no write");

        // R11 unknown operation
        do_cmd(4'h3);
        expect_reg(OFS_RDSTAT, 32'h1, 32'h9, "R11 unknown op perm");
        expect_reg(OFS_CMD, 32'h0001_0030, 32'h0001_00F0, "R2 op field and done");

        // R3 latency
        wr(OFS_ADDR, 32'h1000);
        timed_read();

        // R10 / R2 start and address writes while busy
        wr(OFS_ADDR, 32'h1010);
        wr(OFS_CMD, {24'b0, OP_READ, 4'b0001});
        wr(OFS_ADDR, 32'h1000);
        wr(OFS_CMD, {24'b0, OP_PROG, 4'b0001});
        repeat (LAT + 2) @(negedge clk);
        expect_reg(OFS_ADDR, 32'h1010, 32'hFFFF_FFFF, "R10 address held");
        expect_reg(OFS_CMD, {24'b0, OP_READ, 4'b0}, 32'h0000_00F0, "R2 start while busy ignored");
        expect_reg(OFS_RDATA, 32'h0000_00FF, 32'hFFFF_FFFF, "R2 busy read data");

        // R10 payload write while busy
        set_payload(32'h0000_000F, 32'h0, 32'h0, 32'h0);
        wr(OFS_CMD, {24'b0, OP_READ, 4'b0001});
        wr(OFS_PDATA, 32'hFFFF_FFFF);
        repeat (LAT + 2) @(negedge clk);
        do_cmd(OP_PROG);
        do_cmd(OP_READ);
        expect_reg(OFS_RDATA, 32'h0000_00FF, 32'hFFFF_FFFF, "R10 payload held");

        @(negedge clk);
        bus_sel = 1'b0;
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule